// File: doc/BRIEF.md
# Multi-Output Pixel Coordinate Generator

This block sits beside the digitizers of a sixteen-output infrared array readout. On every pixel-time slot each output delivers one sample, and the block tells the downstream logic where that sample belongs in the 256x256 image. It produces the column index and one row index per output. It also flags the first and the last slot of a frame. In double-read mode it adds a tag that separates integrated-signal samples from reset samples.

Each output walks through groups of sixteen vertically adjacent slots. Output o covers row offset o inside every group of sixteen rows, so the sixteen outputs together fill a full column after sixteen slots. In double-read mode each column is visited twice: first its sixteen signal slots, then sixteen reset slots of the same pixels. A frame-start pulse returns the position to the origin at any time and captures the read mode for the frame. All outputs are registered and appear one clock after the strobe that caused them.

Top module: `pcg_coord_gen`

## Requirements
- R1: `valid_o` is high in the cycle after each cycle with `pix_stb_i` high, and low after every cycle without it. `sof_o` and `eof_o` are low whenever `valid_o` is low.
- R2: In single mode the slot numbered k (counting from 0 within a frame) reports `col_o` = k / 16.
- R3: For slot k, the row of output o (0 to 15) is (k mod 16) * 16 + o in both modes. It is carried in `rows_o[o*8 +: 8]`.
- R4: In double mode slot k reports `col_o` = k / 32 and `rst_tag_o` = bit 4 of k, where 1 marks a reset sample. In single mode `rst_tag_o` is always 0.
- R5: `sof_o` is high exactly for slot 0. `eof_o` is high exactly for slot 4095 in single mode and for slot 8191 in double mode.
- R6: The strobe after the last slot of a frame is slot 0 of the next frame, with the same mode.
- R7: A `frame_start_i` pulse returns the position to slot 0 at any point in a frame. A strobe in the same cycle is slot 0. A pulse without a strobe makes the next strobe slot 0.
- R8: `dbl_mode_i` is sampled only in cycles with `frame_start_i` high, and changes at other times have no effect. After reset the mode is single.
- R9: During and directly after reset, `valid_o`, `sof_o`, `eof_o` and `rst_tag_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_stb_i | input | 1 | One pixel-time slot of samples is present |
| frame_start_i | input | 1 | Restart at slot 0 and capture the mode |
| dbl_mode_i | input | 1 | 1 selects double read, 0 selects single read |
| valid_o | output | 1 | Coordinates below belong to the previous strobe |
| col_o | output | 8 | Column index |
| rows_o | output | 128 | Sixteen 8-bit row indices, output o at bits o*8+7..o*8 |
| sof_o | output | 1 | First slot of the frame |
| eof_o | output | 1 | Last slot of the frame |
| rst_tag_o | output | 1 | Sample is a reset read (double mode only) |

## Verification
The hardest situations to reach are the ones where control inputs collide with the frame walk. Examples are a mode change in the middle of a frame, a restart pulse deep inside a double-read frame, and a restart pulse with no strobe beside it. The stimulus reaches them by running complete frames slot by slot in both modes and wrapping past the last slot. It then restarts at chosen slot counts and toggles the mode input between restart pulses, while an arithmetic model in the bench predicts every field of every slot. Idle gaps are inserted periodically so that the valid pulses are also checked between strobes.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    // Array geometry
    localparam int unsigned NUM_OUT     = 16;   // parallel outputs
    localparam int unsigned BLK_PER_COL = 16;   // slots per column visit
    localparam int unsigned NUM_COL     = 256;  // columns

    localparam int unsigned BLK_W = $clog2(BLK_PER_COL);
    localparam int unsigned COL_W = $clog2(NUM_COL);
    localparam int unsigned ROW_W = $clog2(BLK_PER_COL * NUM_OUT);
    localparam int unsigned ROWS_W = NUM_OUT * ROW_W;

    // Position inside a frame
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             phase;   // 1: reset visit of the column
        logic [BLK_W-1:0] blk;
    } pos_t;

    typedef struct packed {
        pos_t pos;
        logic mode;                // 1: double read
    } cnt_st_t;

    typedef struct packed {
        logic              valid;
        logic              sof;
        logic              eof;
        logic              tag;
        logic [COL_W-1:0]  col;
        logic [ROWS_W-1:0] rows;
    } out_st_t;

endpackage

// File: rtl/pcg_slot_cnt.sv
module pcg_slot_cnt
    import pcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic fs_i,
    input  logic mode_i,
    output pos_t cur_pos_o,
    output logic cur_mode_o,
    output logic cur_first_o,
    output logic cur_last_o
);

    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLK_PER_COL - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COL - 1);

    cnt_st_t st_d, st_q;
    pos_t    cur_pos;
    logic    cur_mode;

    always_comb begin
        cur_mode = fs_i ? mode_i : st_q.mode;
        cur_pos  = fs_i ? '0 : st_q.pos;

        cur_first_o = (cur_pos == '0);
        cur_last_o  = (cur_pos.blk == BLK_LAST) &&
                      (cur_pos.col == COL_LAST) &&
                      (!cur_mode || cur_pos.phase);

        st_d = st_q;
        if (fs_i) begin
            st_d.mode = mode_i;
            st_d.pos  = '0;
        end
        if (stb_i) begin
            st_d.pos = cur_pos;
            if (cur_pos.blk == BLK_LAST) begin
                st_d.pos.blk = '0;
                if (cur_mode && !cur_pos.phase) begin
                    st_d.pos.phase = 1'b1;
                end else begin
                    st_d.pos.phase = 1'b0;
                    st_d.pos.col   = (cur_pos.col == COL_LAST) ? '0
                                                               : cur_pos.col + 1'b1;
                end
            end else begin
                st_d.pos.blk = cur_pos.blk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_pos_o  = cur_pos;
    assign cur_mode_o = cur_mode;

endmodule

// File: rtl/pcg_row_map.sv
module pcg_row_map
    import pcg_pkg::*;
(
    input  logic [BLK_W-1:0]  blk_i,
    output logic [ROWS_W-1:0] rows_o
);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        assign rows_o[o*ROW_W +: ROW_W] =
            ROW_W'(blk_i) * ROW_W'(NUM_OUT) + ROW_W'(o);
    end

endmodule

// File: rtl/pcg_coord_gen.sv
module pcg_coord_gen
    import pcg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pix_stb_i,
    input  logic                   frame_start_i,
    input  logic                   dbl_mode_i,
    output logic                   valid_o,
    output logic [COL_W-1:0]       col_o,
    output logic [ROWS_W-1:0]      rows_o,
    output logic                   sof_o,
    output logic                   eof_o,
    output logic                   rst_tag_o
);

    pos_t              cur_pos;
    logic              cur_mode;
    logic              cur_first;
    logic              cur_last;
    logic [ROWS_W-1:0] cur_rows;

    pcg_slot_cnt u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_i       (pix_stb_i),
        .fs_i        (frame_start_i),
        .mode_i      (dbl_mode_i),
        .cur_pos_o   (cur_pos),
        .cur_mode_o  (cur_mode),
        .cur_first_o (cur_first),
        .cur_last_o  (cur_last)
    );

    pcg_row_map u_rows (
        .blk_i  (cur_pos.blk),
        .rows_o (cur_rows)
    );

    out_st_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = pix_stb_i;
        out_d.sof   = 1'b0;
        out_d.eof   = 1'b0;
        if (pix_stb_i) begin
            out_d.sof  = cur_first;
            out_d.eof  = cur_last;
            out_d.tag  = cur_mode & cur_pos.phase;
            out_d.col  = cur_pos.col;
            out_d.rows = cur_rows;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_o   = out_q.valid;
    assign col_o     = out_q.col;
    assign rows_o    = out_q.rows;
    assign sof_o     = out_q.sof;
    assign eof_o     = out_q.eof;
    assign rst_tag_o = out_q.tag;

endmodule

// File: rtl/pcg_checker.sv
module pcg_checker
    import pcg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pix_stb_i,
    input logic              valid_o,
    input logic [COL_W-1:0]  col_o,
    input logic [ROWS_W-1:0] rows_o,
    input logic              sof_o,
    input logic              eof_o,
    input logic              rst_tag_o
);

    logic [ROW_W-1:0] row0, row1;
    assign row0 = rows_o[ROW_W-1:0];
    assign row1 = rows_o[2*ROW_W-1:ROW_W];

    AST_VALID_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_stb_i) |-> !valid_o); // R1

    AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> valid_o); // R5

    AST_EOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |-> valid_o); // R5

    AST_SOF_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && sof_o) |-> (col_o == '0 && row0 == '0 && !rst_tag_o)); // R5

    AST_EOF_LAST_COL: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |-> (col_o == COL_W'(NUM_COL - 1))); // R5

    AST_ROW_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (row1 == row0 + 1'b1)); // R3

endmodule

bind pcg_coord_gen pcg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_stb_i (pix_stb_i),
    .valid_o   (valid_o),
    .col_o     (col_o),
    .rows_o    (rows_o),
    .sof_o     (sof_o),
    .eof_o     (eof_o),
    .rst_tag_o (rst_tag_o)
);

// File: tb/pcg_coord_gen_tb.sv
`timescale 1ns/1ps
module pcg_coord_gen_tb;
    import pcg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_stb_i = 1'b0;
    logic frame_start_i = 1'b0;
    logic dbl_mode_i = 1'b0;
    logic valid_o, sof_o, eof_o, rst_tag_o;
    logic [COL_W-1:0]  col_o;
    logic [ROWS_W-1:0] rows_o;

    always #10 clk = ~clk;

    pcg_coord_gen u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pix_stb_i     (pix_stb_i),
        .frame_start_i (frame_start_i),
        .dbl_mode_i    (dbl_mode_i),
        .valid_o       (valid_o),
        .col_o         (col_o),
        .rows_o        (rows_o),
        .sof_o         (sof_o),
        .eof_o         (eof_o),
        .rst_tag_o     (rst_tag_o)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string scen = "R2";

    // bench model
    int unsigned       k_model = 0;
    bit                mode_model = 0;
    bit                p_valid = 0, p_sof = 0, p_eof = 0, p_tag = 0;
    int unsigned       p_col = 0;
    logic [ROWS_W-1:0] p_rows = '0;

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s (scenario %s): actual %0h expected %0h",
                     req, scen, act, exp);
        end
    endtask

    task automatic check_pending();
        chk(valid_o == p_valid, "R1", 128'(valid_o), 128'(p_valid));
        if (p_valid) begin
            chk(col_o == COL_W'(p_col), mode_model ? "R4" : "R2",
                128'(col_o), 128'(p_col));
            chk(rows_o == p_rows, "R3", 128'(rows_o), 128'(p_rows));
            chk(rst_tag_o == p_tag, "R4", 128'(rst_tag_o), 128'(p_tag));
            chk(sof_o == p_sof, "R5", 128'(sof_o), 128'(p_sof));
            chk(eof_o == p_eof, "R5", 128'(eof_o), 128'(p_eof));
        end else begin
            chk(!sof_o && !eof_o, "R1", 128'({sof_o, eof_o}), 128'(0));
        end
    endtask

    task automatic cycle(input bit stb, input bit fs, input bit md);
        int unsigned total;
        int unsigned blk;
        @(negedge clk);
        check_pending();
        pix_stb_i = stb;
        frame_start_i = fs;
        dbl_mode_i = md;
        if (fs) begin
            mode_model = md;
            k_model = 0;
        end
        p_valid = stb;
        if (stb) begin
            total = NUM_COL * BLK_PER_COL * (mode_model ? 2 : 1);
            blk = k_model % BLK_PER_COL;
            if (mode_model) begin
                p_col = k_model / (2 * BLK_PER_COL);
                p_tag = ((k_model / BLK_PER_COL) % 2) == 1;
            end else begin
                p_col = k_model / BLK_PER_COL;
                p_tag = 0;
            end
            for (int o = 0; o < NUM_OUT; o++)
                p_rows[o*ROW_W +: ROW_W] = ROW_W'(blk * NUM_OUT + o);
            p_sof = (k_model == 0);
            p_eof = (k_model == total - 1);
            k_model = (k_model + 1) % total;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (4) @(negedge clk);
        scen = "R9";
        chk(!valid_o && !sof_o && !eof_o && !rst_tag_o, "R9",
            128'({valid_o, sof_o, eof_o, rst_tag_o}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o && !sof_o && !eof_o && !rst_tag_o, "R9",
            128'({valid_o, sof_o, eof_o, rst_tag_o}), 128'(0));

        // R8: before any frame start the mode is single
        scen = "R8";
        for (int i = 0; i < 40; i++) cycle(1, 0, 1);

        // R2/R3/R5: full single frame, strobe with frame start is slot 0 (R7)
        scen = "R2";
        cycle(1, 1, 0);
        for (int i = 1; i < 4096; i++) cycle(1, 0, 0);
        // R6: wrap into the next frame
        scen = "R6";
        for (int i = 0; i < 20; i++) cycle(1, 0, 0);

        // R4: full double frame with idle gaps, then wrap (R6)
        scen = "R4";
        cycle(1, 1, 1);
        for (int i = 1; i < 8192 + 40; i++) begin
            if (i % 7 == 0) cycle(0, 0, 1);
            cycle(1, 0, 1);
        end

        // R8: mode toggled without frame start is ignored
        scen = "R8";
        cycle(1, 1, 0);
        for (int i = 0; i < 60; i++) cycle(1, 0, i % 2 == 0);

        // R7: restart deep inside a double frame
        scen = "R7";
        cycle(1, 1, 1);
        for (int i = 0; i < 1000; i++) cycle(1, 0, 1);
        cycle(1, 1, 1);
        for (int i = 0; i < 50; i++) cycle(1, 0, 0);
        // R7: restart pulse without a strobe
        cycle(0, 1, 0);
        for (int i = 0; i < 40; i++) cycle(1, 0, 1);

        cycle(0, 0, 0);
        cycle(0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule